// File: doc/BRIEF.md
# Transmit Phase-Compensation FIFO

This block carries transmit words from the fabric side of a serial link into the transceiver side. The two sides run at exactly the same frequency (0 PPM) but with an unknown, fixed phase between their clocks. The FIFO absorbs that phase offset. It does no rate matching. When the two clocks do drift apart, it reports the fault on one sticky error output.

The write side takes its words from one of two sources, chosen by `pipe_mode`: a PIPE-style transmit port or a plain fabric data port. The write clock is also selectable: a shared clock from the bonded clock divider, or a core clock that the user supplies. Pointers cross between the two domains in Gray code through synchronizer chains. After reset the read side waits until a set fill level has built up, so that occupancy settles near half the depth. From then on it pops one word per read clock. `dest_sel` picks which of three downstream consumers receives the word stream: byte serializer, 8B/10B encoder or direct serializer.

Top module: `txpc_fifo`

## Requirements
- R1: With `pipe_mode`=1 the FIFO stores `pipe_data` qualified by `pipe_valid`. With `pipe_mode`=0 it stores `fab_data` qualified by `fab_valid`. The unselected source never reaches the output.
- R2: With `use_core_clk`=1 the write side runs on `core_clk`. With `use_core_clk`=0 it runs on `shared_clk`. The unselected clock has no effect, even when it is stopped or runs at another rate.
- R3: When the selected write clock and `rd_clk` are equal in frequency and writes are continuous, `fifo_err` stays 0. Words leave in write order, with none lost and none repeated.
- R4: After reset the read side consumes nothing, and all `out_valid` bits stay 0, until it sees DEPTH/2 − SYNC_STAGES words (2 by default). It then reads one word per `rd_clk` and never stops.
- R5: A write arriving while the FIFO is full is discarded. Stored words are not overwritten, so the output sequence stays strictly increasing. `fifo_err` rises.
- R6: A read cycle that finds the FIFO empty repeats the last output word, skips no word and raises `fifo_err`.
- R7: Once high, `fifo_err` stays high until `rst_n` is asserted. Reset clears it.
- R8: `dest_sel` routes the stream: 0 drives `bser_data` and `out_valid[0]`; 1 drives `enc_data` and `out_valid[1]`; 2 drives `ser_data` and `out_valid[2]`; 3 selects no consumer. Outputs that are not selected read 0.
- R9: While `rst_n` is low, `out_valid`, `fifo_err` and all three data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shared_clk | input | 1 | Bonded write clock from the clock divider |
| core_clk | input | 1 | User-supplied write clock |
| use_core_clk | input | 1 | 1 selects `core_clk` as the write clock (static) |
| rd_clk | input | 1 | Transceiver-side read clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised per domain |
| pipe_mode | input | 1 | 1 selects the PIPE source (static) |
| pipe_valid | input | 1 | PIPE word valid |
| pipe_data | input | DATA_W | PIPE transmit word |
| fab_valid | input | 1 | Fabric word valid |
| fab_data | input | DATA_W | Fabric transmit word |
| dest_sel | input | 2 | Downstream consumer select (static) |
| bser_data | output | DATA_W | Word to byte serializer |
| enc_data | output | DATA_W | Word to 8B/10B encoder |
| ser_data | output | DATA_W | Word to serializer |
| out_valid | output | 3 | Per-consumer valid, at most one bit set |
| fifo_err | output | 1 | Sticky overflow-or-underrun flag (read domain) |

## Verification
The bench tags every word with its source and a running count, then follows the count at the output. This separates a dropped word from a repeated one. A skewed pair of clocks pushes the FIFO into overflow in one test and underrun in another. A design that overwrote unread slots on overflow would send the sequence backwards. A design that advanced its pointer on underrun would skip words. A non-sticky flag would fall between fault events. A wrong start threshold, or a clock or source mux wired the wrong way, shows up in three ways: the fill-up delay is wrong, the error flag rises under a skewed unselected clock, or a foreign tag appears at the output.

// File: rtl/txpc_pkg.sv
`timescale 1ns/1ps
package txpc_pkg;
   // downstream consumer codes: the index of the out_valid bit equals the code
   typedef enum logic [1:0] {
      DEST_BYTESER = 2'd0,
      DEST_ENCODER = 2'd1,
      DEST_SERIAL  = 2'd2,
      DEST_NONE    = 2'd3
   } dest_e;

   localparam int unsigned NUM_DEST  = 3;
   localparam int unsigned MIN_SYNC  = 2;
   localparam int unsigned MIN_DEPTH = 4;
endpackage

// File: rtl/txpc_rst_sync.sv
`timescale 1ns/1ps
module txpc_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/txpc_sync_bus.sv
`timescale 1ns/1ps
module txpc_sync_bus #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/txpc_wr_ctrl.sv
`timescale 1ns/1ps
module txpc_wr_ctrl #(
   parameter  int unsigned DATA_W = 20,
   parameter  int unsigned DEPTH  = 8,
   localparam int unsigned AW     = $clog2(DEPTH),
   localparam int unsigned PW     = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_mode,
   input  logic              pipe_valid,
   input  logic [DATA_W-1:0] pipe_data,
   input  logic              fab_valid,
   input  logic [DATA_W-1:0] fab_data,
   input  logic [PW-1:0]     rgray_s,
   output logic              wr_en,
   output logic              wr_blocked,
   output logic [AW-1:0]     wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [PW-1:0]     wgray
);
   logic          src_valid;
   logic          full;
   logic [PW-1:0] wbin, wbin_nxt;

   // source select: PIPE port or plain fabric port
   always_comb begin
      src_valid = pipe_mode ? pipe_valid : fab_valid;
      wr_data   = pipe_mode ? pipe_data  : fab_data;
   end

   // full when the write pointer has lapped the synchronised read pointer
   assign full       = (wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
   assign wr_en      = src_valid & ~full;
   assign wr_blocked = src_valid & full;
   assign wbin_nxt   = wbin + PW'(wr_en);
   assign wr_addr    = wbin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else begin
         wbin  <= wbin_nxt;
         wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      end
   end
endmodule

// File: rtl/txpc_rd_ctrl.sv
`timescale 1ns/1ps
module txpc_rd_ctrl #(
   parameter  int unsigned DATA_W    = 20,
   parameter  int unsigned DEPTH     = 8,
   parameter  int unsigned START_LVL = 2,
   localparam int unsigned AW        = $clog2(DEPTH),
   localparam int unsigned PW        = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PW-1:0]     wgray_s,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [AW-1:0]     rd_addr,
   output logic [PW-1:0]     rgray,
   output logic              started,
   output logic              starve,
   output logic [DATA_W-1:0] data_q
);
   logic [PW-1:0] wbin_s, rbin, rbin_nxt, level;
   logic          go, empty, take;

   // Gray to binary on the synchronised write pointer
   always_comb begin
      wbin_s[PW-1] = wgray_s[PW-1];
      for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
   end

   assign level    = wbin_s - rbin;
   assign empty    = (level == '0);
   assign go       = started | (level >= PW'(START_LVL));
   assign take     = go & ~empty;
   assign starve   = go & empty;
   assign rbin_nxt = rbin + PW'(1);
   assign rd_addr  = rbin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         rbin    <= '0;
         rgray   <= '0;
         data_q  <= '0;
      end else begin
         if (go) started <= 1'b1;
         if (take) begin
            rbin   <= rbin_nxt;
            rgray  <= rbin_nxt ^ (rbin_nxt >> 1);
            data_q <= mem_rdata;
         end
      end
   end
endmodule

// File: rtl/txpc_dest_route.sv
`timescale 1ns/1ps
module txpc_dest_route
   import txpc_pkg::*;
#(
   parameter int unsigned DATA_W = 20
) (
   input  logic                active,
   input  logic [1:0]          dest_sel,
   input  logic [DATA_W-1:0]   din,
   output logic [DATA_W-1:0]   bser_data,
   output logic [DATA_W-1:0]   enc_data,
   output logic [DATA_W-1:0]   ser_data,
   output logic [NUM_DEST-1:0] out_valid
);
   logic [DATA_W-1:0] lane [NUM_DEST];

   for (genvar g = 0; g < NUM_DEST; g++) begin : g_lane
      localparam dest_e CODE = dest_e'(g);
      logic hit;
      assign hit          = active && (dest_e'(dest_sel) == CODE);
      assign out_valid[g] = hit;
      assign lane[g]      = hit ? din : '0;
   end

   assign bser_data = lane[DEST_BYTESER];
   assign enc_data  = lane[DEST_ENCODER];
   assign ser_data  = lane[DEST_SERIAL];
endmodule

// File: rtl/txpc_fifo.sv
`timescale 1ns/1ps
module txpc_fifo
   import txpc_pkg::*;
#(
   parameter  int unsigned DATA_W      = 20,
   parameter  int unsigned DEPTH       = 8,
   parameter  int unsigned SYNC_STAGES = 2,
   localparam int unsigned AW          = $clog2(DEPTH),
   localparam int unsigned PW          = AW + 1,
   localparam int unsigned START_LVL   = DEPTH / 2 - SYNC_STAGES
) (
   input  logic              shared_clk,
   input  logic              core_clk,
   input  logic              use_core_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              pipe_mode,
   input  logic              pipe_valid,
   input  logic [DATA_W-1:0] pipe_data,
   input  logic              fab_valid,
   input  logic [DATA_W-1:0] fab_data,
   input  logic [1:0]        dest_sel,
   output logic [DATA_W-1:0] bser_data,
   output logic [DATA_W-1:0] enc_data,
   output logic [DATA_W-1:0] ser_data,
   output logic [2:0]        out_valid,
   output logic              fifo_err
);
   // elaboration-time parameter checks
   initial begin : p_cfg
      assert (DEPTH >= MIN_DEPTH && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "DEPTH must be a power of two, at least %0d", MIN_DEPTH);
      assert (SYNC_STAGES >= MIN_SYNC)
         else $fatal(1, "SYNC_STAGES must be at least %0d", MIN_SYNC);
      assert (DEPTH / 2 > SYNC_STAGES)
         else $fatal(1, "DEPTH/2 must exceed SYNC_STAGES");
      assert (DATA_W >= 1) else $fatal(1, "DATA_W must be positive");
   end

   // write clock: static choice between the bonded clock and the user clock
   logic wr_clk;
   assign wr_clk = use_core_clk ? core_clk : shared_clk;

   logic wr_srst_n, rd_srst_n;

   txpc_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
      .clk(wr_clk), .arst_n(rst_n), .srst_n(wr_srst_n));
   txpc_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
      .clk(rd_clk), .arst_n(rst_n), .srst_n(rd_srst_n));

   logic              wr_en, wr_blocked;
   logic [AW-1:0]     wr_addr, rd_addr;
   logic [DATA_W-1:0] wr_data, mem_rdata, rd_q;
   logic [PW-1:0]     wr_gray, rd_gray, wr_gray_s, rd_gray_s;
   logic              rd_started, rd_starve;
   logic              wr_ovf, ovf_s, rd_undr;

   txpc_wr_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
      .clk(wr_clk), .rst_n(wr_srst_n),
      .pipe_mode(pipe_mode), .pipe_valid(pipe_valid), .pipe_data(pipe_data),
      .fab_valid(fab_valid), .fab_data(fab_data),
      .rgray_s(rd_gray_s),
      .wr_en(wr_en), .wr_blocked(wr_blocked), .wr_addr(wr_addr),
      .wr_data(wr_data), .wgray(wr_gray));

   // storage: written in the write domain, read combinationally in the read domain
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign mem_rdata = mem[rd_addr];

   txpc_sync_bus #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rd_srst_n), .d(wr_gray), .q(wr_gray_s));
   txpc_sync_bus #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(wr_srst_n), .d(rd_gray), .q(rd_gray_s));

   txpc_rd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .START_LVL(START_LVL)) u_rd (
      .clk(rd_clk), .rst_n(rd_srst_n),
      .wgray_s(wr_gray_s), .mem_rdata(mem_rdata),
      .rd_addr(rd_addr), .rgray(rd_gray),
      .started(rd_started), .starve(rd_starve), .data_q(rd_q));

   // sticky fault capture in each domain
   always_ff @(posedge wr_clk or negedge wr_srst_n) begin
      if (!wr_srst_n)      wr_ovf <= 1'b0;
      else if (wr_blocked) wr_ovf <= 1'b1;
   end

   always_ff @(posedge rd_clk or negedge rd_srst_n) begin
      if (!rd_srst_n)     rd_undr <= 1'b0;
      else if (rd_starve) rd_undr <= 1'b1;
   end

   txpc_sync_bus #(.W(1), .STAGES(SYNC_STAGES)) u_ovf (
      .clk(rd_clk), .rst_n(rd_srst_n), .d(wr_ovf), .q(ovf_s));

   assign fifo_err = rd_undr | ovf_s;

   txpc_dest_route #(.DATA_W(DATA_W)) u_route (
      .active(rd_started), .dest_sel(dest_sel), .din(rd_q),
      .bser_data(bser_data), .enc_data(enc_data), .ser_data(ser_data),
      .out_valid(out_valid));
endmodule

// File: rtl/txpc_fifo_chk.sv
`timescale 1ns/1ps
module txpc_fifo_chk #(
   parameter int unsigned DATA_W = 20,
   parameter int unsigned PW     = 4
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              wr_srst_n,
   input logic              rd_srst_n,
   input logic              wr_blocked,
   input logic [PW-1:0]     wr_gray,
   input logic [PW-1:0]     rd_gray,
   input logic              rd_started,
   input logic              rd_starve,
   input logic [DATA_W-1:0] rd_q,
   input logic [2:0]        out_valid,
   input logic              fifo_err
);
   // R3: pointers crossing domains move by at most one Gray bit per edge
   a_r3_wgray_step: assert property (@(posedge wr_clk) disable iff (!wr_srst_n)
      $countones(wr_gray ^ $past(wr_gray)) <= 1);
   a_r3_rgray_step: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
      $countones(rd_gray ^ $past(rd_gray)) <= 1);

   // R4: nothing consumed before reads begin; reading never stops once begun
   a_r4_no_early_read: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
      !rd_started |-> rd_gray == '0);
   a_r4_start_holds: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
      rd_started |=> rd_started);

   // R5: a blocked write leaves the write pointer where it was
   a_r5_drop_on_full: assert property (@(posedge wr_clk) disable iff (!wr_srst_n)
      wr_blocked |=> $stable(wr_gray));

   // R6: an empty read cycle keeps the output word and the read pointer
   a_r6_hold_word: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
      rd_starve |=> $stable(rd_q));
   a_r6_hold_ptr: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
      rd_starve |=> $stable(rd_gray));

   // R7: the error flag only clears through reset
   a_r7_err_sticky: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
      fifo_err |=> fifo_err);

   // R8: at most one consumer is ever valid
   a_r8_one_dest: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
      $onehot0(out_valid));
endmodule

bind txpc_fifo txpc_fifo_chk #(.DATA_W(DATA_W), .PW(PW)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk),
   .wr_srst_n(wr_srst_n), .rd_srst_n(rd_srst_n),
   .wr_blocked(wr_blocked), .wr_gray(wr_gray), .rd_gray(rd_gray),
   .rd_started(rd_started), .rd_starve(rd_starve), .rd_q(rd_q),
   .out_valid(out_valid), .fifo_err(fifo_err));

// File: tb/tb_txpc_fifo.sv
`timescale 1ns/1ps
module tb_txpc_fifo;
   localparam int DW = 20;
   localparam logic [3:0] TAG_PIPE = 4'hA;
   localparam logic [3:0] TAG_FAB  = 4'h5;

   logic shared_clk, core_clk, rd_clk, rst_n, use_core_clk, pipe_mode;
   logic pipe_valid, fab_valid;
   logic [DW-1:0] pipe_data, fab_data, bser_data, enc_data, ser_data;
   logic [1:0] dest_sel;
   logic [2:0] out_valid;
   logic fifo_err;

   txpc_fifo dut (
      .shared_clk(shared_clk), .core_clk(core_clk), .use_core_clk(use_core_clk),
      .rd_clk(rd_clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
      .pipe_valid(pipe_valid), .pipe_data(pipe_data),
      .fab_valid(fab_valid), .fab_data(fab_data), .dest_sel(dest_sel),
      .bser_data(bser_data), .enc_data(enc_data), .ser_data(ser_data),
      .out_valid(out_valid), .fifo_err(fifo_err));

   // 125 MHz nominal clocks; half periods are adjustable to create skew
   real sh_half = 4.0, co_half = 4.0, rd_half = 4.0;
   bit  sh_run = 1'b1, co_run = 1'b1;

   initial begin shared_clk = 0; forever begin #(sh_half); if (sh_run) shared_clk = ~shared_clk; end end
   initial begin core_clk = 0; #1.5; forever begin #(co_half); if (co_run) core_clk = ~core_clk; end end
   initial begin rd_clk = 0; #3; forever #(rd_half) rd_clk = ~rd_clk; end

   int checks = 0, errors = 0;
   bit done = 0, stop = 0;
   int dest = 0;

   // monitor results
   int n_vld, n_rep, n_skip, n_back, n_tag, n_idle, n_badv, n_errdrop;
   bit err_seen;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input bit core, input bit pmode, input int dst);
      rst_n = 0; pipe_valid = 0; fab_valid = 0; pipe_data = '0; fab_data = '0;
      use_core_clk = core; pipe_mode = pmode; dest = dst; dest_sel = 2'(dst);
      repeat (4) @(negedge rd_clk);
      rst_n = 1;
   endtask

   task automatic wr_loop();
      logic [15:0] c;
      c = '0;
      while (!stop) begin
         if (use_core_clk) @(negedge core_clk); else @(negedge shared_clk);
         pipe_data = {TAG_PIPE, c}; fab_data = {TAG_FAB, c};
         pipe_valid = 1; fab_valid = 1;
         c++;
      end
   endtask

   task automatic rd_mon(input int n, input logic [3:0] tag);
      logic [15:0] prev, diff;
      logic [DW-1:0] d, others;
      bit have;
      have = 0; prev = '0;
      n_vld = 0; n_rep = 0; n_skip = 0; n_back = 0; n_tag = 0;
      n_idle = 0; n_badv = 0; n_errdrop = 0; err_seen = 0;
      repeat (n) begin
         @(negedge rd_clk);
         if (err_seen && !fifo_err) n_errdrop++;
         if (fifo_err) err_seen = 1;
         case (dest)
            0: begin d = bser_data; others = enc_data | ser_data; end
            1: begin d = enc_data;  others = bser_data | ser_data; end
            2: begin d = ser_data;  others = bser_data | enc_data; end
            default: begin d = '0; others = bser_data | enc_data | ser_data; end
         endcase
         if (others != '0) n_idle++;
         if (out_valid != 3'b000) begin
            n_vld++;
            if (dest > 2 || out_valid != (3'b001 << dest)) n_badv++;
            if (d[DW-1:DW-4] != tag) n_tag++;
            if (have) begin
               diff = d[15:0] - prev;
               if (diff == 0) n_rep++;
               else if (diff == 1) ;
               else if (diff < 16'h8000) n_skip++;
               else n_back++;
            end
            prev = d[15:0]; have = 1;
         end
      end
   endtask

   task automatic run_case(input int n, input logic [3:0] tag);
      stop = 0;
      fork
         wr_loop();
         begin rd_mon(n, tag); stop = 1; end
      join
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      rst_n = 0; pipe_valid = 1; fab_valid = 1;
      repeat (3) @(negedge rd_clk);
      chk(out_valid == 3'b000, "R9", "out_valid in reset", out_valid, 0);
      chk(fifo_err == 1'b0, "R9", "fifo_err in reset", fifo_err, 0);
      chk((bser_data | enc_data | ser_data) == '0, "R9", "data in reset",
          bser_data | enc_data | ser_data, 0);
   endtask

   task automatic t_fabric();
      sh_half = 4.0; rd_half = 4.0;
      do_reset(0, 0, 0);
      run_case(300, TAG_FAB);
      chk(fifo_err == 0, "R3", "err at 0 PPM fabric", fifo_err, 0);
      chk(n_vld > 250, "R3", "valid words fabric", n_vld, 290);
      chk(n_rep == 0 && n_skip == 0 && n_back == 0, "R3", "order faults fabric",
          n_rep + n_skip + n_back, 0);
      chk(n_tag == 0, "R1", "non-fabric words", n_tag, 0);
      chk(n_badv == 0, "R8", "dest 0 valid bit", n_badv, 0);
      chk(n_idle == 0, "R8", "unselected outputs nonzero", n_idle, 0);
   endtask

   task automatic t_pipe();
      do_reset(0, 1, 1);
      run_case(300, TAG_PIPE);
      chk(n_tag == 0, "R1", "non-PIPE words", n_tag, 0);
      chk(n_vld > 250, "R1", "valid words PIPE", n_vld, 290);
      chk(n_badv == 0 && n_idle == 0, "R8", "dest 1 routing", n_badv + n_idle, 0);
      chk(fifo_err == 0, "R3", "err at 0 PPM PIPE", fifo_err, 0);
   endtask

   task automatic t_core_clk();
      sh_half = 2.5; co_half = 4.0;   // unselected clock runs at the wrong rate
      do_reset(1, 0, 2);
      run_case(300, TAG_FAB);
      chk(fifo_err == 0, "R2", "err with core clock selected", fifo_err, 0);
      chk(n_rep == 0 && n_skip == 0 && n_back == 0, "R2", "order on core clock",
          n_rep + n_skip + n_back, 0);
      chk(n_badv == 0 && n_idle == 0, "R8", "dest 2 routing", n_badv + n_idle, 0);
      sh_half = 4.0;
   endtask

   task automatic t_shared_only();
      co_run = 0;                     // unselected clock stopped
      do_reset(0, 0, 0);
      run_case(200, TAG_FAB);
      chk(n_vld > 150, "R2", "words on shared clock, core stopped", n_vld, 190);
      chk(fifo_err == 0, "R2", "err with core clock stopped", fifo_err, 0);
      co_run = 1;
   endtask

   task automatic t_start();
      int cnt;
      do_reset(0, 0, 0);
      cnt = 0; stop = 0;
      fork
         wr_loop();
         begin
            while (cnt < 40 && out_valid == 3'b000) begin @(negedge rd_clk); cnt++; end
            stop = 1;
         end
      join
      chk(cnt >= 5 && cnt <= 16, "R4", "read cycles before first valid", cnt, 7);
   endtask

   task automatic t_dest_none();
      do_reset(0, 0, 3);
      run_case(150, TAG_FAB);
      chk(n_vld == 0, "R8", "valid with dest 3", n_vld, 0);
      chk(n_idle == 0, "R8", "data with dest 3", n_idle, 0);
   endtask

   task automatic t_overflow();
      sh_half = 3.5; rd_half = 4.0;   // writer faster than reader
      do_reset(0, 0, 0);
      run_case(300, TAG_FAB);
      chk(fifo_err == 1, "R5", "err on overflow", fifo_err, 1);
      chk(n_skip > 0, "R5", "dropped words seen", n_skip, 1);
      chk(n_back == 0 && n_rep == 0, "R5", "stored words overwritten", n_back + n_rep, 0);
      chk(n_errdrop == 0, "R7", "err fell after overflow", n_errdrop, 0);
      sh_half = 4.0;
      rst_n = 0;
      repeat (3) @(negedge rd_clk);
      chk(fifo_err == 0, "R7", "err cleared by reset", fifo_err, 0);
   endtask

   task automatic t_underrun();
      sh_half = 4.5; rd_half = 4.0;   // writer slower than reader
      do_reset(0, 0, 1);
      run_case(300, TAG_FAB);
      chk(fifo_err == 1, "R6", "err on underrun", fifo_err, 1);
      chk(n_rep > 0, "R6", "repeated words seen", n_rep, 1);
      chk(n_skip == 0 && n_back == 0, "R6", "words skipped on underrun", n_skip + n_back, 0);
      chk(n_errdrop == 0, "R7", "err fell after underrun", n_errdrop, 0);
      sh_half = 4.0;
   endtask

   initial begin
      t_reset();
      t_fabric();
      t_pipe();
      t_core_clk();
      t_shared_only();
      t_start();
      t_dest_none();
      t_overflow();
      t_underrun();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule